// File: doc/BRIEF.md
# Clocked Serial Master Transmitter

This block is a synchronous serial master that sends one data word per transfer on a serial clock line and a serial data line. A host sets it up through a small write-only register port. One register holds the power, transmit-enable and bit-order bits. A second picks the serial clock divider, and a third sets the transfer length. A write to the data register starts a transfer.

While a transfer runs, `busy` is high. The serial clock toggles at a divided rate and the data line changes on each falling clock edge. On the final rising clock edge the clock returns to its idle high level and `busy` drops. In that same cycle the block raises a one-cycle completion pulse. The host waits for that pulse before it writes the next word. Clearing power or transmit enable stops any transfer at once.

Top module: `ser_tx_master`

## Requirements
- R1: After reset, `sclk` is 1, `sdo` is 1, `busy` is 0 and `done_irq` is 0.
- R2: Register address 0 is control: bit 7 is power, bit 6 is transmit enable, and bit 0 selects the order (1 = most significant bit first). Writing C1h enables the block with MSB-first order.
- R3: Register address 1, bits [1:0], hold the divider d. Each serial clock half-period lasts 2^d system clock cycles, so 00h gives a serial clock of the system clock divided by 2.
- R4: Register address 2, bits [2:0], hold the length. A value of 0 means 8 bits, and values 1 to 7 mean that many bits.
- R5: When power and transmit enable are both set and `busy` is 0, a write to address 3 starts a transfer. In the next cycle `busy` is 1, `sclk` is 0, and `sdo` carries the first bit.
- R6: In MSB-first order, bits go out from bit N-1 down to bit 0. `sdo` changes only while `sclk` falls and is stable at each rising edge.
- R7: In LSB-first order, bit 0 goes out first, and the timing is otherwise identical.
- R8: `busy` stays high for exactly (2N-1)*2^d cycles. It drops at the final rising `sclk` edge, and `sclk` is 1 whenever `busy` is 0.
- R9: `done_irq` is a one-cycle pulse that occurs in the same cycle in which `busy` falls at the end of a completed transfer.
- R10: A write to address 3 while `busy` is 1 is ignored, and the running transfer continues unchanged.
- R11: A write to address 3 while power or transmit enable is clear starts nothing.
- R12: A control write that clears power or transmit enable during a transfer ends it. In the next cycle `busy` is 0 and `sclk` is 1, and no `done_irq` is raised.
- R13: While idle, `sdo` holds the last bit sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| sclk | output | 1 | Serial clock, idle high |
| sdo | output | 1 | Serial data output |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
The hardest states to reach are a data write or a control write landing in the middle of a transfer. These have to be timed against an exact cycle count. The bench follows each transfer cycle by cycle and injects the write at a chosen cycle index inside that loop. It then reassembles the bits seen at each rising `sclk` edge, which shows whether the original word went out untouched or the transfer stopped with no completion pulse.

// File: rtl/ser_tx_master.sv
module ser_tx_master #(
  parameter int DW   = 8,
  parameter int DIVW = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  output logic       sclk,
  output logic       sdo,
  output logic       busy,
  output logic       done_irq
);
  localparam int LW = $clog2(DW);
  localparam int CW = 1 << DIVW;

  logic            pwr, txe, msb;
  logic [DIVW-1:0] div, div_q;
  logic [LW-1:0]   len, last, k;
  logic            msb_q;
  logic [DW-1:0]   sh;
  logic [CW-1:0]   cnt;

  wire en    = pwr & txe;
  wire start = wr_en && wr_addr == 2'd3 && en && !busy;
  wire abort = busy && wr_en && wr_addr == 2'd0 && !(wr_data[7] && wr_data[6]);

  wire [CW-1:0] half_m1  = (CW'(1) << div_q) - CW'(1);
  wire [LW-1:0] nlast    = (len == '0) ? LW'(DW - 1) : len - LW'(1);
  wire [LW-1:0] k1       = k + LW'(1);
  wire [LW-1:0] idx_next = msb_q ? last - k1 : k1;
  wire [LW-1:0] idx0     = msb ? nlast : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr <= 1'b0; txe <= 1'b0; msb <= 1'b0;
      div <= '0;   len <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        2'd0: begin pwr <= wr_data[7]; txe <= wr_data[6]; msb <= wr_data[0]; end
        2'd1: div <= wr_data[DIVW-1:0];
        2'd2: len <= wr_data[LW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; msb_q <= 1'b0; div_q <= '0; last <= '0; k <= '0; cnt <= '0;
      busy <= 1'b0; sclk <= 1'b1; sdo <= 1'b1; done_irq <= 1'b0;
    end else begin
      done_irq <= 1'b0;
      if (start) begin
        sh    <= wr_data[DW-1:0];
        msb_q <= msb;
        div_q <= div;
        last  <= nlast;
        k     <= '0;
        cnt   <= '0;
        busy  <= 1'b1;
        sclk  <= 1'b0;
        sdo   <= wr_data[idx0];
      end else if (abort) begin
        busy <= 1'b0;
        sclk <= 1'b1;
      end else if (busy) begin
        if (cnt == half_m1) begin
          cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            if (k == last) begin
              busy     <= 1'b0;
              done_irq <= 1'b1;
            end
          end else begin
            sclk <= 1'b0;
            k    <= k1;
            sdo  <= sh[idx_next];
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ser_tx_master_chk.sv
module ser_tx_master_chk (
  input logic clk,
  input logic rst_n,
  input logic sclk,
  input logic sdo,
  input logic busy,
  input logic done_irq,
  input logic start,
  input logic abort
);
  AST_IRQ_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done_irq |=> !done_irq); // R9
  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n) done_irq |-> (!busy && $past(busy))); // R9
  AST_IDLE_HIGH:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> sclk); // R8
  AST_SDO_RISE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(sclk) |-> $stable(sdo)); // R6
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n) start |=> (busy && !sclk)); // R5
  AST_ABORT_STOP: assert property (@(posedge clk) disable iff (!rst_n) abort |=> (!busy && sclk && !done_irq)); // R12
endmodule

bind ser_tx_master ser_tx_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdo(sdo), .busy(busy),
  .done_irq(done_irq), .start(start), .abort(abort)
);

// File: tb/ser_tx_master_tb.sv
module ser_tx_master_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic sclk, sdo, busy, done_irq;
  int checks = 0, fails = 0, cyc = 0;

  ser_tx_master u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sclk(sclk), .sdo(sdo), .busy(busy), .done_irq(done_irq));

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // data: [55:48] len: [47:40] div: [39:32] ctrl: [31:24] stream: [23:16] busy cycles: [15:0]
  localparam logic [55:0] VEC [6] = '{
    {8'hA5, 8'h00, 8'h00, 8'hC1, 8'hA5, 16'd15},
    {8'hA5, 8'h00, 8'h01, 8'hC1, 8'hA5, 16'd30},
    {8'h1E, 8'h00, 8'h00, 8'hC0, 8'h78, 16'd15},
    {8'h3C, 8'h04, 8'h02, 8'hC1, 8'hC0, 16'd28},
    {8'h16, 8'h05, 8'h00, 8'hC0, 8'h68, 16'd9},
    {8'h01, 8'h01, 8'h01, 8'hC1, 8'h80, 16'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic monitor(input int inj, input logic [1:0] ia, input logic [7:0] id,
                         output logic [7:0] stream, output int cycles, output int irqs,
                         output bit irq_end);
    logic [7:0] s = '0; int n = 0; logic ps, pd;
    cycles = 0; irqs = 0;
    while (busy && cycles < 1000) begin
      if (cycles == inj) begin wr_en = 1'b1; wr_addr = ia; wr_data = id; end
      ps = sclk; pd = sdo; cycles++;
      @(negedge clk);
      wr_en = 1'b0;
      if (!ps && sclk) begin s = {s[6:0], pd}; n++; end
      if (done_irq) irqs++;
    end
    irq_end = done_irq;
    stream = (n == 0) ? 8'h00 : s << (8 - n);
    @(negedge clk);
    if (done_irq) irqs++;
  endtask

  initial begin
    logic [7:0] st; int cy, iq; bit ie;
    repeat (3) @(negedge clk);
    check(sclk === 1'b1 && sdo === 1'b1, "R1 lines", {sclk, sdo}, 2'b11);
    check(busy === 1'b0 && done_irq === 1'b0, "R1 flags", {busy, done_irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 6; i++) begin
      wr(2'd0, VEC[i][31:24]); wr(2'd1, VEC[i][39:32]); wr(2'd2, VEC[i][47:40]);
      wr(2'd3, VEC[i][55:48]);
      check(busy === 1'b1 && sclk === 1'b0, "R5 start", {busy, sclk}, 2'b10);
      monitor(-1, 2'd0, 8'h00, st, cy, iq, ie);
      check(st == VEC[i][23:16], "R2/R4/R6/R7 bit stream", st, VEC[i][23:16]);
      check(cy == int'(VEC[i][15:0]), "R3/R8 busy length", cy, VEC[i][15:0]);
      check(iq == 1 && ie, "R9 single irq at end", iq, 1);
      check(sclk === 1'b1, "R8 idle high", sclk, 1);
    end

    // R10: data write mid-transfer ignored
    wr(2'd0, 8'hC1); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
    wr(2'd3, 8'hA5);
    monitor(3, 2'd3, 8'h0F, st, cy, iq, ie);
    check(st == 8'hA5, "R10 stream", st, 8'hA5);
    check(cy == 15 && iq == 1, "R10 timing", cy, 15);

    // R13: idle sdo holds last bit (3C, 4 bits MSB first ends with 0)
    wr(2'd2, 8'h04); wr(2'd3, 8'h3C);
    monitor(-1, 2'd0, 8'h00, st, cy, iq, ie);
    repeat (5) @(negedge clk);
    check(sdo === 1'b0, "R13 hold last", sdo, 0);

    // R11: power off ignores data write
    wr(2'd0, 8'h41); wr(2'd3, 8'hFF);
    check(busy === 1'b0, "R11 no start (power off)", busy, 0);
    wr(2'd0, 8'h81); wr(2'd3, 8'hFF);
    check(busy === 1'b0, "R11 no start (tx off)", busy, 0);

    // R12: abort mid-transfer
    wr(2'd0, 8'hC1); wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
    monitor(4, 2'd0, 8'h00, st, cy, iq, ie);
    check(cy == 5, "R12 abort cycles", cy, 5);
    check(iq == 0 && sclk === 1'b1, "R12 no irq idle high", iq, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule